// File: doc/BRIEF.md
# 64-bit Alarm Timer with Prescaler

This block is one general-purpose timer channel. A 64-bit counter steps up or down once every N input clocks, where N comes from a 16-bit prescaler field, and it runs only while its enable bit is set. A 64-bit compare value arms an alarm. When the alarm fires it can latch an interrupt status bit that drives a level interrupt, send a one-cycle edge pulse, and optionally reload the counter from a 64-bit load value. Firing clears the alarm's arm bit, so software must arm it again before the next alarm.

Software reaches the channel through a small 32-bit register bus. Writes are accepted in the cycle they are presented. A read request returns its data one cycle later with `rd_valid` set. The bus has no back-pressure: every request is served at once. The live counter cannot be read directly. Software writes the update strobe to copy the counter into a snapshot pair, then reads that pair. The counter is loaded by writing the 64-bit load value and then the reload strobe.

Top module: `alarm_timer64`

## Requirements
- R1: After reset every register reads 0, the counter is 0, and `irq_level` and `irq_edge` are low.
- R2: Byte offsets are: 0x00 config, 0x04/0x08 snapshot low/high, 0x0C update strobe, 0x10/0x14 alarm low/high, 0x18/0x1C load low/high, 0x20 reload strobe, 0x24 interrupt enable (bit 0), 0x28 raw interrupt status (bit 0), 0x2C interrupt clear. Config, alarm, load and enable read back the value written, and config bits 9:0 read 0. The strobe offsets (0x0C, 0x20, 0x2C) read 0. A request with `rd_en` high returns `rd_valid`=1 and the data on the next cycle.
- R3: Any write to 0x0C copies the live counter into the snapshot pair. Reads of 0x04/0x08 return that copy and do not follow the running counter.
- R4: Any write to 0x20 loads {load high, load low} into the counter on that edge. If a counting step falls on the same edge, the load wins.
- R5: Config bits 28:13 hold the divider D. While config bit 31 is 1 the counter steps once every D clocks. A field of 1 acts as 2, and a field of 0 acts as 65536. Every config write restarts the prescaler from zero. While bit 31 is 0 the counter holds its value.
- R6: Config bit 30 = 1 makes the counter count up. Bit 30 = 0 makes it count down.
- R7: An alarm fires when config bit 10 (arm) is 1 and the counter equals {alarm high, alarm low}. Firing clears bit 10. While bit 10 is 0 no alarm fires.
- R8: With config bit 29 (auto-reload) set, an alarm loads the counter with {load high, load low}. This load takes priority over a counting step on the same edge.
- R9: With config bit 11 set, an alarm sets the status bit. Writing 1 in bit 0 to 0x2C clears the status bit. `irq_level` equals status AND interrupt enable.
- R10: With config bit 12 set and the interrupt enable bit at 1, an alarm produces a single-cycle `irq_edge` pulse on the cycle after the match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write request, accepted in the same cycle |
| wr_addr | input | 6 | Write byte offset |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read request |
| rd_addr | input | 6 | Read byte offset |
| rd_valid | output | 1 | Read data valid, one cycle after `rd_en` |
| rd_data | output | 32 | Read data |
| irq_level | output | 1 | Level interrupt: status AND enable |
| irq_edge | output | 1 | One-cycle alarm pulse |

## Verification
The bench measures counting exactly over fixed clock windows. A prescaler that ignored the divider, mapped a field of 1 or 0 to the wrong divisor, or failed to restart on a config write would leave a different count in the snapshot. It lands a reload strobe on the same edge as a counting step, and runs an auto-reloading alarm. If the wrong source took priority, the count would end off by one or would run past the alarm value. It checks that the arm bit clears after firing and that exactly one edge pulse is produced. It also checks that the interrupt enable gates both outputs while the raw status still latches. Finally it checks that snapshots stay frozen while the counter runs, so a design that returned the live counter would be caught.

// File: rtl/atm_pkg.sv
package atm_pkg;
  localparam int ADDR_W = 6;

  localparam logic [ADDR_W-1:0] OFS_CFG   = 6'h00;
  localparam logic [ADDR_W-1:0] OFS_SNAPL = 6'h04;
  localparam logic [ADDR_W-1:0] OFS_SNAPH = 6'h08;
  localparam logic [ADDR_W-1:0] OFS_UPD   = 6'h0C;
  localparam logic [ADDR_W-1:0] OFS_ALML  = 6'h10;
  localparam logic [ADDR_W-1:0] OFS_ALMH  = 6'h14;
  localparam logic [ADDR_W-1:0] OFS_LDL   = 6'h18;
  localparam logic [ADDR_W-1:0] OFS_LDH   = 6'h1C;
  localparam logic [ADDR_W-1:0] OFS_RLD   = 6'h20;
  localparam logic [ADDR_W-1:0] OFS_IEN   = 6'h24;
  localparam logic [ADDR_W-1:0] OFS_IST   = 6'h28;
  localparam logic [ADDR_W-1:0] OFS_ICLR  = 6'h2C;

  // config field positions
  localparam int B_ARM   = 10;
  localparam int B_LVL   = 11;
  localparam int B_EDG   = 12;
  localparam int B_DIV   = 13;
  localparam int B_AUTO  = 29;
  localparam int B_UP    = 30;
  localparam int B_RUN   = 31;
  localparam int RSVD_W  = 10;
endpackage

// File: rtl/atm_prescaler.sv
module atm_prescaler #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [DIV_W-1:0] div_field,
  output logic             tick
);
  logic [DIV_W-1:0] pcnt_q;
  logic [DIV_W-1:0] limit;

  // terminal value is effective divisor minus one; 0 -> full range, 1 -> 2
  always_comb begin
    if (div_field == '0)
      limit = '1;
    else if (div_field == DIV_W'(1))
      limit = DIV_W'(1);
    else
      limit = div_field - DIV_W'(1);
  end

  assign tick = run && (pcnt_q == limit);

  always_ff @(posedge clk) begin
    if (!rst_n)
      pcnt_q <= '0;
    else if (restart)
      pcnt_q <= '0;
    else if (run)
      pcnt_q <= tick ? '0 : pcnt_q + DIV_W'(1);
  end
endmodule

// File: rtl/atm_counter.sv
module atm_counter #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             up,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt <= '0;
    else if (load)
      cnt <= load_val;
    else if (step)
      cnt <= up ? cnt + CNT_W'(1) : cnt - CNT_W'(1);
  end
endmodule

// File: rtl/atm_irq.sv
module atm_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic level_en,
  input  logic edge_en,
  input  logic ien,
  input  logic clr,
  output logic status,
  output logic irq_level,
  output logic irq_edge
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status   <= 1'b0;
      irq_edge <= 1'b0;
    end else begin
      if (hit && level_en)
        status <= 1'b1;
      else if (clr)
        status <= 1'b0;
      irq_edge <= hit && edge_en && ien;
    end
  end

  assign irq_level = status && ien;
endmodule

// File: rtl/alarm_timer64.sv
module alarm_timer64
  import atm_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DIV_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq_level,
  output logic              irq_edge
);
  localparam int CNT_W = 2 * DATA_W;
  localparam logic [DATA_W-1:0] CFG_MASK = {{(DATA_W-RSVD_W){1'b1}}, {RSVD_W{1'b0}}};

  logic [DATA_W-1:0] cfg_q;
  logic [CNT_W-1:0]  alarm_q, load_q, snap_q, cnt;
  logic              ien_q;
  logic              status;
  logic [DATA_W-1:0] rd_mux;

  logic cfg_wr, upd_wr, reload_wr, clr_wr;
  logic alarm_hit, tick, ctr_load;

  assign cfg_wr    = wr_en && (wr_addr == OFS_CFG);
  assign upd_wr    = wr_en && (wr_addr == OFS_UPD);
  assign reload_wr = wr_en && (wr_addr == OFS_RLD);
  assign clr_wr    = wr_en && (wr_addr == OFS_ICLR) && wr_data[0];

  assign alarm_hit = cfg_q[B_ARM] && (cnt == alarm_q);
  assign ctr_load  = reload_wr || (alarm_hit && cfg_q[B_AUTO]);

  // register file
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      alarm_q <= '0;
      load_q  <= '0;
      snap_q  <= '0;
      ien_q   <= 1'b0;
    end else begin
      if (cfg_wr)
        cfg_q <= wr_data & CFG_MASK;
      else if (alarm_hit)
        cfg_q[B_ARM] <= 1'b0;
      if (upd_wr)
        snap_q <= cnt;
      if (wr_en) begin
        unique case (wr_addr)
          OFS_ALML: alarm_q[DATA_W-1:0]     <= wr_data;
          OFS_ALMH: alarm_q[CNT_W-1:DATA_W] <= wr_data;
          OFS_LDL:  load_q[DATA_W-1:0]      <= wr_data;
          OFS_LDH:  load_q[CNT_W-1:DATA_W]  <= wr_data;
          OFS_IEN:  ien_q                   <= wr_data[0];
          default: ;
        endcase
      end
    end
  end

  // read path
  always_comb begin
    rd_mux = '0;
    unique case (rd_addr)
      OFS_CFG:   rd_mux = cfg_q;
      OFS_SNAPL: rd_mux = snap_q[DATA_W-1:0];
      OFS_SNAPH: rd_mux = snap_q[CNT_W-1:DATA_W];
      OFS_ALML:  rd_mux = alarm_q[DATA_W-1:0];
      OFS_ALMH:  rd_mux = alarm_q[CNT_W-1:DATA_W];
      OFS_LDL:   rd_mux = load_q[DATA_W-1:0];
      OFS_LDH:   rd_mux = load_q[CNT_W-1:DATA_W];
      OFS_IEN:   rd_mux = DATA_W'(ien_q);
      OFS_IST:   rd_mux = DATA_W'(status);
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en)
        rd_data <= rd_mux;
    end
  end

  atm_prescaler #(.DIV_W(DIV_W)) u_pre (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (cfg_q[B_RUN]),
    .restart   (cfg_wr),
    .div_field (cfg_q[B_DIV +: DIV_W]),
    .tick      (tick)
  );

  atm_counter #(.CNT_W(CNT_W)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (tick),
    .up       (cfg_q[B_UP]),
    .load     (ctr_load),
    .load_val (load_q),
    .cnt      (cnt)
  );

  atm_irq u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .hit       (alarm_hit),
    .level_en  (cfg_q[B_LVL]),
    .edge_en   (cfg_q[B_EDG]),
    .ien       (ien_q),
    .clr       (clr_wr),
    .status    (status),
    .irq_level (irq_level),
    .irq_edge  (irq_edge)
  );
endmodule

// File: rtl/atm_checker.sv
module atm_checker #(
  parameter int CNT_W = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rd_en,
  input logic             rd_valid,
  input logic             irq_level,
  input logic             irq_edge,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] load_val,
  input logic             alarm_hit,
  input logic             arm,
  input logic             run,
  input logic             cfg_wr,
  input logic             reload_wr,
  input logic             clr_wr
);
  assert_rd_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);
  assert_rd_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);
  assert_reload_takes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    reload_wr |=> (cnt == $past(load_val)));
  assert_hold_when_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !reload_wr && !alarm_hit) |=> $stable(cnt));
  assert_arm_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_hit && !cfg_wr) |=> !arm);
  assert_status_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && !alarm_hit) |=> !irq_level);
  assert_edge_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_edge |=> !irq_edge);
endmodule

bind alarm_timer64 atm_checker #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rd_en     (rd_en),
  .rd_valid  (rd_valid),
  .irq_level (irq_level),
  .irq_edge  (irq_edge),
  .cnt       (cnt),
  .load_val  (load_q),
  .alarm_hit (alarm_hit),
  .arm       (cfg_q[10]),
  .run       (cfg_q[31]),
  .cfg_wr    (cfg_wr),
  .reload_wr (reload_wr),
  .clr_wr    (clr_wr)
);

// File: tb/alarm_timer64_tb_top.sv
module alarm_timer64_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [5:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [5:0]  rd_addr = '0;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic        irq_level, irq_edge;

  int tests = 0;
  int fails = 0;
  int edge_pulses = 0;
  bit done = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  alarm_timer64 dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .irq_level(irq_level), .irq_edge(irq_edge)
  );

  function automatic logic [31:0] cfgw(bit run, bit up, bit auto_rl, logic [15:0] dv,
                                       bit edg, bit lvl, bit arm);
    return {run, up, auto_rl, dv, edg, lvl, arm, 10'b0};
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    if (irq_edge) edge_pulses++;
    if (rd_valid) begin
      tests++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R2 unexpected read data %h expected none", rd_data);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rd_data !== e) begin
          fails++;
          $display("FAIL %s got %h expected %h", t, rd_data, e);
        end
      end
    end
  end

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic chk(input bit ok, input string t, input int got, input int e);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s got %0d expected %0d", t, got, e);
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    for (int i = 0; i < 200000; i++) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(irq_level == 0 && irq_edge == 0, "R1 irq low after reset", irq_level, 0);
    rd(6'h00, 32'h0, "R1 config reset");
    rd(6'h04, 32'h0, "R1 snapshot reset");
    rd(6'h18, 32'h0, "R1 load reset");

    // R2 readback and strobe reads
    wr(6'h10, 32'hDEADBEEF);
    wr(6'h14, 32'h12345678);
    rd(6'h10, 32'hDEADBEEF, "R2 alarm low readback");
    rd(6'h14, 32'h12345678, "R2 alarm high readback");
    wr(6'h00, 32'h0000_03FF);
    rd(6'h00, 32'h0, "R2 reserved config bits read 0");
    rd(6'h0C, 32'h0, "R2 update strobe reads 0");
    rd(6'h20, 32'h0, "R2 reload strobe reads 0");
    wr(6'h14, 32'h0);

    // R4 reload, R3 snapshot
    wr(6'h18, 32'd100);
    wr(6'h1C, 32'd1);
    wr(6'h20, 32'h0);
    wr(6'h0C, 32'h0);
    rd(6'h04, 32'd100, "R4 reload low");
    rd(6'h08, 32'd1, "R4 reload high");

    // R5/R6 up count, divider 4, 40-cycle window -> 10 steps
    wr(6'h1C, 32'h0);
    wr(6'h18, 32'h0);
    wr(6'h20, 32'h0);
    wr(6'h00, cfgw(1, 1, 0, 16'd4, 0, 0, 0));
    wait_n(39);
    wr(6'h00, cfgw(0, 1, 0, 16'd4, 0, 0, 0));
    wr(6'h0C, 32'h0);
    rd(6'h04, 32'd10, "R5 divide-by-4 up count");

    // R3 snapshot is frozen while counter runs
    wr(6'h00, cfgw(1, 1, 0, 16'd4, 0, 0, 0));
    wait_n(20);
    rd(6'h04, 32'd10, "R3 snapshot not live");
    wr(6'h00, 32'h0);

    // R6 down count, divider field 1 acts as 2; R7 disarmed alarm stays quiet
    wr(6'h18, 32'd1000);
    wr(6'h20, 32'h0);
    wr(6'h10, 32'd995);
    wr(6'h00, cfgw(1, 0, 0, 16'd1, 1, 1, 0));
    wait_n(19);
    wr(6'h00, cfgw(0, 0, 0, 16'd1, 1, 1, 0));
    wr(6'h0C, 32'h0);
    rd(6'h04, 32'd990, "R6 down count with divider 1 as 2");
    rd(6'h28, 32'h0, "R7 no alarm while disarmed");

    // R5 divider field 0 = 65536: 65535-cycle window gives no step
    wr(6'h18, 32'h0);
    wr(6'h20, 32'h0);
    wr(6'h00, cfgw(1, 1, 0, 16'd0, 0, 0, 0));
    wait_n(65534);
    wr(6'h00, cfgw(0, 1, 0, 16'd0, 0, 0, 0));
    wr(6'h0C, 32'h0);
    rd(6'h04, 32'd0, "R5 divider 0 as 65536");

    // R7/R9/R10 alarm with level and edge
    wr(6'h24, 32'h1);
    wr(6'h20, 32'h0);
    wr(6'h10, 32'd5);
    wr(6'h00, cfgw(1, 1, 0, 16'd2, 1, 1, 1));
    wait_n(11);
    chk(irq_edge == 1, "R10 edge pulse after match", irq_edge, 1);
    chk(irq_level == 1, "R9 level set by alarm", irq_level, 1);
    @(negedge clk);
    chk(irq_edge == 0, "R10 edge pulse one cycle", irq_edge, 0);
    chk(irq_level == 1, "R9 level holds", irq_level, 1);
    rd(6'h00, cfgw(1, 1, 0, 16'd2, 1, 1, 0), "R7 arm bit self-clears");
    wr(6'h2C, 32'h1);
    chk(irq_level == 0, "R9 clear by write-1", irq_level, 0);
    rd(6'h28, 32'h0, "R9 status cleared");
    wr(6'h00, 32'h0);
    wait_n(4);
    chk(edge_pulses == 1, "R10 exactly one edge pulse", edge_pulses, 1);

    // R9/R10 enable gating
    wr(6'h24, 32'h0);
    wr(6'h20, 32'h0);
    wr(6'h00, cfgw(1, 1, 0, 16'd2, 1, 1, 1));
    wait_n(15);
    chk(irq_level == 0, "R9 level gated by enable", irq_level, 0);
    rd(6'h28, 32'h1, "R9 raw status latched");
    wr(6'h24, 32'h1);
    chk(irq_level == 1, "R9 level after enable", irq_level, 1);
    chk(edge_pulses == 1, "R10 edge gated by enable", edge_pulses, 1);
    wr(6'h2C, 32'h1);
    wr(6'h00, 32'h0);

    // R8 auto-reload on alarm
    wr(6'h18, 32'd3);
    wr(6'h20, 32'h0);
    wr(6'h10, 32'd6);
    wr(6'h00, cfgw(1, 1, 1, 16'd2, 0, 0, 1));
    wait_n(9);
    wr(6'h00, cfgw(0, 1, 1, 16'd2, 0, 0, 0));
    wr(6'h0C, 32'h0);
    rd(6'h04, 32'd5, "R8 auto-reload on alarm");

    // R4 reload beats a counting step on the same edge
    wr(6'h18, 32'd500);
    wr(6'h00, cfgw(1, 1, 0, 16'd2, 0, 0, 0));
    wait_n(9);
    wr(6'h20, 32'h0);
    wr(6'h00, 32'h0);
    wr(6'h0C, 32'h0);
    rd(6'h04, 32'd500, "R4 reload wins over step");

    wait_n(4);
    chk(exp_q.size() == 0, "R2 all reads answered", exp_q.size(), 0);
    finish_run();
  end
endmodule